// File: doc/BRIEF.md
# MOESI Snooping Coherence Controller

This block keeps the coherence state of a small, directly indexed array of cache lines on behalf of one processor in a snooping multiprocessor. Each line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. The processor side presents read, write and evict requests by line number. Misses and upgrades become bus requests, which the controller holds until the bus reports completion together with a sampled "another cache has a copy" flag. Evicting dirty data produces a write-back pulse.

Transactions that other caches place on the bus are snooped in the same cycle. The controller answers at once with a copy-held response and a data-supply indication, and updates the line state at the next clock edge. A dirty line that a reader snoops is kept and becomes the designated supplier. A lookup port returns the current state of any line, so the tag and data side can decide on hits. Data storage, tags, arbitration and memory are not part of the block.

Top module: `moesi_ctrl`

## Requirements
- R1: After reset every line reads Invalid on the lookup port, and `busy` and `bus_req_valid` are low. State codes: Invalid 0, Shared 1, Exclusive 2, Owned 3, Modified 4.
- R2: A processor read (`cpu_op` 0) to an Invalid line raises `bus_req_valid` with bus op read (1) on the next cycle. When `bus_done` arrives, the line becomes Shared if `bus_shared` is high and Exclusive otherwise.
- R3: A processor read to a line in any valid state issues no bus request and changes no state.
- R4: A processor write (`cpu_op` 1) to an Invalid line issues bus op read-exclusive (2). On completion the line becomes Modified.
- R5: A processor write to a Shared or Owned line issues bus op upgrade (3). On completion the line becomes Modified.
- R6: A processor write to an Exclusive or Modified line sets it to Modified at the next edge with no bus request.
- R7: A snooped bus read on a Modified line asserts `snp_supply` and moves the line to Owned. On an Owned line it asserts `snp_supply` and the line stays Owned. On an Exclusive line it moves the line to Shared without supply. A Shared line is unchanged.
- R8: A snooped read-exclusive moves any valid line to Invalid, and asserts `snp_supply` in that cycle when the line was Modified or Owned.
- R9: A snooped upgrade moves a Shared or Owned line to Invalid without supply. Exclusive and Modified lines are unaffected.
- R10: `snp_shared` is high in a snoop cycle exactly when the snooped line is in a valid state.
- R11: Evicting (`cpu_op` 2) a Modified or Owned line pulses `wb_valid` with `wb_line` for one cycle after acceptance. Evicting any valid line leaves it Invalid, and clean lines produce no pulse.
- R12: While a bus request is outstanding, `busy` is high, the request op and line stay stable, and processor requests are ignored.
- R13: A snoop takes effect before a processor request to the same line in the same cycle. A bus completion overrides a same-cycle snoop on its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 read, 1 write, 2 evict, 3 no-op |
| cpu_line | input | IDX_W | Line addressed by the processor |
| busy | output | 1 | Bus request outstanding; requests ignored |
| bus_req_valid | output | 1 | Bus request being driven |
| bus_req_op | output | 2 | 1 read, 2 read-exclusive, 3 upgrade |
| bus_req_line | output | IDX_W | Line of the bus request |
| bus_done | input | 1 | Outstanding bus request completes this cycle |
| bus_shared | input | 1 | Another cache holds the line (sampled with bus_done) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | Snooped op, same code as bus_req_op |
| snp_line | input | IDX_W | Snooped line |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies data for the snoop |
| wb_valid | output | 1 | One-cycle write-back indication |
| wb_line | output | IDX_W | Line to write back |
| lkp_line | input | IDX_W | Line to look up |
| lkp_state | output | 3 | State of the looked-up line |

## Verification
The hardest situation to reach is a collision on one line, in one cycle, between a snoop and either a processor request or a bus completion. An example is a snooped bus read that demotes an Exclusive line in the same cycle as a processor write, which must then issue an upgrade rather than write silently. Directed steps create each such collision on purpose. The random phase then confines processor and snoop addresses to four lines and grants the bus with random delays, so that collisions and stale pending requests recur many times against the bench's reference model.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        CPU_RD  = 2'd0,
        CPU_WR  = 2'd1,
        CPU_EV  = 2'd2,
        CPU_NOP = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_UPG  = 2'd3
    } bus_op_e;

    function automatic logic is_valid(line_st_e s);
        return s != ST_I;
    endfunction

    function automatic logic is_dirty(line_st_e s);
        return (s == ST_M) || (s == ST_O);
    endfunction

    function automatic line_st_e snoop_next(line_st_e s, bus_op_e op);
        line_st_e n;
        n = s;
        unique case (op)
            BUS_RD:   if (s == ST_M) n = ST_O; else if (s == ST_E) n = ST_S;
            BUS_RDX:  n = ST_I;
            BUS_UPG:  if (s == ST_S || s == ST_O) n = ST_I;
            default:  n = s;
        endcase
        return n;
    endfunction

    function automatic logic snoop_supplies(line_st_e s, bus_op_e op);
        return is_dirty(s) && (op == BUS_RD || op == BUS_RDX);
    endfunction

endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  line_st_e         snp_st,
    input  logic             req_we,
    input  logic [IDX_W-1:0] req_idx,
    input  line_st_e         req_st,
    output line_st_e         st_q [NUM_LINES]
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g] <= ST_I;
            end else if (req_we && req_idx == IDX_W'(g)) begin
                st_q[g] <= req_st;
            end else if (snp_we && snp_idx == IDX_W'(g)) begin
                st_q[g] <= snp_st;
            end
        end
    end

endmodule

// File: rtl/moesi_snoop_unit.sv
module moesi_snoop_unit
    import moesi_pkg::*;
(
    input  logic     snp_valid,
    input  bus_op_e  snp_op,
    input  line_st_e cur_st,
    output logic     we,
    output line_st_e nxt_st,
    output logic     shared_o,
    output logic     supply_o
);

    always_comb begin
        we       = snp_valid && (snp_op != BUS_NONE);
        nxt_st   = snoop_next(cur_st, snp_op);
        shared_o = snp_valid && is_valid(cur_st);
        supply_o = snp_valid && snoop_supplies(cur_st, snp_op);
    end

endmodule

// File: rtl/moesi_req_fsm.sv
module moesi_req_fsm
    import moesi_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_valid,
    input  cpu_op_e          cpu_op,
    input  logic [IDX_W-1:0] cpu_line,
    input  line_st_e         cur_st,
    input  logic             bus_done,
    input  logic             bus_shared,
    output logic             busy,
    output logic             bus_req_valid,
    output bus_op_e          bus_req_op,
    output logic [IDX_W-1:0] bus_req_line,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_line,
    output logic             upd_we,
    output logic [IDX_W-1:0] upd_line,
    output line_st_e         upd_st
);

    logic             pend_q;
    bus_op_e          op_q;
    logic [IDX_W-1:0] line_q;
    logic             wb_q;
    logic [IDX_W-1:0] wbl_q;
    logic             accept, complete, issue, do_wb;
    bus_op_e          iss_op;

    assign accept   = cpu_valid && !pend_q && (cpu_op != CPU_NOP);
    assign complete = pend_q && bus_done;

    always_comb begin
        issue    = 1'b0;
        iss_op   = BUS_NONE;
        do_wb    = 1'b0;
        upd_we   = 1'b0;
        upd_line = cpu_line;
        upd_st   = cur_st;
        if (complete) begin
            upd_we   = 1'b1;
            upd_line = line_q;
            upd_st   = (op_q == BUS_RD) ? (bus_shared ? ST_S : ST_E) : ST_M;
        end else if (accept) begin
            unique case (cpu_op)
                CPU_RD: begin
                    if (cur_st == ST_I) begin
                        issue  = 1'b1;
                        iss_op = BUS_RD;
                    end
                end
                CPU_WR: begin
                    if (cur_st == ST_I) begin
                        issue  = 1'b1;
                        iss_op = BUS_RDX;
                    end else if (cur_st == ST_S || cur_st == ST_O) begin
                        issue  = 1'b1;
                        iss_op = BUS_UPG;
                    end else begin
                        upd_we = 1'b1;
                        upd_st = ST_M;
                    end
                end
                CPU_EV: begin
                    if (is_valid(cur_st)) begin
                        upd_we = 1'b1;
                        upd_st = ST_I;
                        do_wb  = is_dirty(cur_st);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            op_q   <= BUS_NONE;
            line_q <= '0;
            wb_q   <= 1'b0;
            wbl_q  <= '0;
        end else begin
            if (complete) begin
                pend_q <= 1'b0;
                op_q   <= BUS_NONE;
            end else if (issue) begin
                pend_q <= 1'b1;
                op_q   <= iss_op;
                line_q <= cpu_line;
            end
            wb_q <= do_wb;
            if (do_wb) wbl_q <= cpu_line;
        end
    end

    assign busy          = pend_q;
    assign bus_req_valid = pend_q;
    assign bus_req_op    = op_q;
    assign bus_req_line  = line_q;
    assign wb_valid      = wb_q;
    assign wb_line       = wbl_q;

    // R12: request held unchanged until completion
    p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
        pend_q && !bus_done |=> bus_req_valid && $stable(bus_req_line) && $stable(bus_req_op));

    // R12: a live request always carries a real bus op
    p_req_has_op_r12: assert property (@(posedge clk) disable iff (rst)
        bus_req_valid |-> bus_req_op != BUS_NONE);

    // R11: write-back only follows an evict request
    p_wb_after_evict_r11: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(cpu_valid) && $past(cpu_op) == CPU_EV);

    // R2: busy only rises after a processor request
    p_busy_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cpu_valid));

endmodule

// File: rtl/moesi_ctrl.sv
module moesi_ctrl
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_valid,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_line,
    output logic             busy,
    output logic             bus_req_valid,
    output logic [1:0]       bus_req_op,
    output logic [IDX_W-1:0] bus_req_line,
    input  logic             bus_done,
    input  logic             bus_shared,
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [IDX_W-1:0] snp_line,
    output logic             snp_shared,
    output logic             snp_supply,
    output logic             wb_valid,
    output logic [IDX_W-1:0] wb_line,
    input  logic [IDX_W-1:0] lkp_line,
    output logic [2:0]       lkp_state
);

    line_st_e         st_q [NUM_LINES];
    line_st_e         snp_cur, snp_nxt, cpu_cur, upd_st;
    logic             snp_we, upd_we;
    logic [IDX_W-1:0] upd_line;
    bus_op_e          req_op;

    assign snp_cur = st_q[snp_line];
    // processor request sees the state after a same-cycle snoop
    assign cpu_cur = (snp_we && snp_line == cpu_line) ? snp_nxt : st_q[cpu_line];

    moesi_snoop_unit u_snoop (
        .snp_valid (snp_valid),
        .snp_op    (bus_op_e'(snp_op)),
        .cur_st    (snp_cur),
        .we        (snp_we),
        .nxt_st    (snp_nxt),
        .shared_o  (snp_shared),
        .supply_o  (snp_supply)
    );

    moesi_req_fsm #(.IDX_W(IDX_W)) u_req (
        .clk           (clk),
        .rst           (rst),
        .cpu_valid     (cpu_valid),
        .cpu_op        (cpu_op_e'(cpu_op)),
        .cpu_line      (cpu_line),
        .cur_st        (cpu_cur),
        .bus_done      (bus_done),
        .bus_shared    (bus_shared),
        .busy          (busy),
        .bus_req_valid (bus_req_valid),
        .bus_req_op    (req_op),
        .bus_req_line  (bus_req_line),
        .wb_valid      (wb_valid),
        .wb_line       (wb_line),
        .upd_we        (upd_we),
        .upd_line      (upd_line),
        .upd_st        (upd_st)
    );

    moesi_line_store #(.NUM_LINES(NUM_LINES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .snp_we  (snp_we),
        .snp_idx (snp_line),
        .snp_st  (snp_nxt),
        .req_we  (upd_we),
        .req_idx (upd_line),
        .req_st  (upd_st),
        .st_q    (st_q)
    );

    assign bus_req_op = req_op;
    assign lkp_state  = st_q[lkp_line];

    // R8: read-exclusive snoop leaves the line Invalid unless the processor side wrote it
    p_rdx_kills_r8: assert property (@(posedge clk) disable iff (rst)
        snp_valid && snp_op == 2'd2 && !(upd_we && upd_line == snp_line)
        |=> st_q[$past(snp_line)] == ST_I);

    // R7: a snooped read never leaves Exclusive or Modified behind
    p_rd_demotes_r7: assert property (@(posedge clk) disable iff (rst)
        snp_valid && snp_op == 2'd1 && !(upd_we && upd_line == snp_line)
        |=> st_q[$past(snp_line)] != ST_E && st_q[$past(snp_line)] != ST_M);

endmodule

// File: tb/moesi_ctrl_tb_top.sv
`timescale 1ns/1ps
module moesi_ctrl_tb_top;

    localparam int NL = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cpu_valid;
    logic [1:0]    cpu_op;
    logic [IW-1:0] cpu_line;
    logic          busy, bus_req_valid;
    logic [1:0]    bus_req_op;
    logic [IW-1:0] bus_req_line;
    logic          bus_done, bus_shared;
    logic          snp_valid;
    logic [1:0]    snp_op;
    logic [IW-1:0] snp_line;
    logic          snp_shared, snp_supply;
    logic          wb_valid;
    logic [IW-1:0] wb_line;
    logic [IW-1:0] lkp_line;
    logic [2:0]    lkp_state;

    always #2.5 clk = ~clk;

    moesi_ctrl #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_line(cpu_line),
        .busy(busy), .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op),
        .bus_req_line(bus_req_line), .bus_done(bus_done), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_line(snp_line),
        .snp_shared(snp_shared), .snp_supply(snp_supply),
        .wb_valid(wb_valid), .wb_line(wb_line),
        .lkp_line(lkp_line), .lkp_state(lkp_state)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model
    logic [2:0]    m [NL];
    logic          m_pend;
    logic [1:0]    m_op;
    logic [IW-1:0] m_line;
    logic          m_wb;
    logic [IW-1:0] m_wbl;

    function automatic logic [2:0] ref_snoop(logic [2:0] s, logic [1:0] op);
        if (op == 2'd2) return 3'd0;
        if (op == 2'd1) return (s == 3'd4) ? 3'd3 : (s == 3'd2) ? 3'd1 : s;
        if (op == 2'd3) return (s == 3'd1 || s == 3'd3) ? 3'd0 : s;
        return s;
    endfunction

    function automatic logic ref_supply(logic [2:0] s, logic [1:0] op);
        return (op == 2'd1 || op == 2'd2) && (s == 3'd4 || s == 3'd3);
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic cycle(input logic cv, input logic [1:0] cop, input logic [IW-1:0] cl,
                         input logic sv, input logic [1:0] sop, input logic [IW-1:0] sl,
                         input logic bd, input logic bs, input logic [IW-1:0] lk,
                         input string tag);
        logic [2:0] post [NL];
        logic [2:0] st;
        logic       nwb;
        @(negedge clk);
        cpu_valid = cv; cpu_op = cop; cpu_line = cl;
        snp_valid = sv; snp_op = sop; snp_line = sl;
        bus_done = bd; bus_shared = bs; lkp_line = lk;
        #1;
        check(8'(lkp_state), 8'(m[lk]), tag, "lookup state");
        check(8'(busy), 8'(m_pend), "R12", "busy");
        check(8'(bus_req_valid), 8'(m_pend), tag, "bus_req_valid");
        if (m_pend) begin
            check(8'(bus_req_op), 8'(m_op), tag, "bus_req_op");
            check(8'(bus_req_line), 8'(m_line), "R12", "bus_req_line");
        end
        check(8'(wb_valid), 8'(m_wb), "R11", "wb_valid");
        if (m_wb) check(8'(wb_line), 8'(m_wbl), "R11", "wb_line");
        if (sv) begin
            check(8'(snp_shared), 8'(m[sl] != 3'd0), "R10", "snp_shared");
            check(8'(snp_supply), 8'(ref_supply(m[sl], sop)),
                  (sop == 2'd1) ? "R7" : (sop == 2'd2) ? "R8" : "R9", "snp_supply");
        end
        for (int i = 0; i < NL; i++) post[i] = m[i];
        if (sv && sop != 2'd0) post[sl] = ref_snoop(m[sl], sop);
        nwb = 1'b0;
        if (m_pend && bd) begin
            post[m_line] = (m_op == 2'd1) ? (bs ? 3'd1 : 3'd2) : 3'd4;
            m_pend = 1'b0;
        end else if (cv && !m_pend && cop != 2'd3) begin
            st = post[cl];
            case (cop)
                2'd0: if (st == 3'd0) begin m_pend = 1'b1; m_op = 2'd1; m_line = cl; end
                2'd1: begin
                    if (st == 3'd0) begin m_pend = 1'b1; m_op = 2'd2; m_line = cl; end
                    else if (st == 3'd1 || st == 3'd3) begin m_pend = 1'b1; m_op = 2'd3; m_line = cl; end
                    else post[cl] = 3'd4;
                end
                default: if (st != 3'd0) begin
                    if (st >= 3'd3) begin nwb = 1'b1; m_wbl = cl; end
                    post[cl] = 3'd0;
                end
            endcase
        end
        @(posedge clk);
        for (int i = 0; i < NL; i++) m[i] = post[i];
        m_wb = nwb;
    endtask

    // shorthands
    task automatic cpu(input logic [1:0] op, input logic [IW-1:0] l, input string tag);
        cycle(1, op, l, 0, 0, 0, 0, 0, l, tag);
    endtask
    task automatic snp(input logic [1:0] op, input logic [IW-1:0] l, input string tag);
        cycle(0, 0, 0, 1, op, l, 0, 0, l, tag);
    endtask
    task automatic grant(input logic sh, input logic [IW-1:0] l, input string tag);
        cycle(0, 0, 0, 0, 0, 0, 1, sh, l, tag);
    endtask
    task automatic idle(input logic [IW-1:0] l, input string tag);
        cycle(0, 0, 0, 0, 0, 0, 0, 0, l, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        cpu_valid = 0; cpu_op = 0; cpu_line = 0;
        snp_valid = 0; snp_op = 0; snp_line = 0;
        bus_done = 0; bus_shared = 0; lkp_line = 0;
        for (int i = 0; i < NL; i++) m[i] = 3'd0;
        m_pend = 0; m_op = 0; m_line = 0; m_wb = 0; m_wbl = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        for (int i = 0; i < NL; i++) idle(IW'(i), "R1");

        // R2 read miss, no sharer -> Exclusive
        cpu(2'd0, 1, "R2"); idle(1, "R2"); grant(0, 1, "R2");
        idle(1, "R2");
        // R3 read hit
        cpu(2'd0, 1, "R3"); idle(1, "R3");
        // R6 silent write E->M
        cpu(2'd1, 1, "R6"); idle(1, "R6");
        // R7 snooped read: M->O with supply, O stays O
        snp(2'd1, 1, "R7"); snp(2'd1, 1, "R7"); idle(1, "R7");
        // R5 write on Owned -> upgrade
        cpu(2'd1, 1, "R5"); grant(0, 1, "R5"); idle(1, "R5");
        cpu(2'd1, 1, "R6"); idle(1, "R6");
        // R11 dirty evict
        cpu(2'd2, 1, "R11"); idle(1, "R11"); idle(1, "R11");
        // R4 write miss
        cpu(2'd1, 2, "R4"); idle(2, "R4"); grant(1, 2, "R4"); idle(2, "R4");
        // R8 read-exclusive on M: supply and invalidate
        snp(2'd2, 2, "R8"); idle(2, "R8");
        // R2 read miss with sharer -> Shared; R5 upgrade from Shared
        cpu(2'd0, 3, "R2"); grant(1, 3, "R2"); idle(3, "R2");
        cpu(2'd1, 3, "R5"); grant(0, 3, "R5"); idle(3, "R5");
        // R9 upgrade snoop on Shared
        cpu(2'd0, 5, "R2"); grant(1, 5, "R2");
        snp(2'd3, 5, "R9"); idle(5, "R9");
        // R11 clean evict
        cpu(2'd0, 6, "R2"); grant(0, 6, "R2");
        cpu(2'd2, 6, "R11"); idle(6, "R11");
        // R12 ignored requests while busy
        cpu(2'd0, 4, "R12");
        cpu(2'd1, 7, "R12"); cpu(2'd1, 1, "R12"); cpu(2'd2, 3, "R12");
        idle(7, "R12"); grant(0, 4, "R12"); idle(4, "R12");
        // R13 snoop read on Exclusive with same-cycle write -> upgrade
        cycle(1, 2'd1, 4, 1, 2'd1, 4, 0, 0, 4, "R13");
        idle(4, "R13"); grant(0, 4, "R13"); idle(4, "R13");
        // R13 completion overrides same-cycle snoop
        cpu(2'd0, 8, "R13");
        cycle(0, 0, 0, 1, 2'd2, 8, 1, 0, 8, "R13");
        idle(8, "R13");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] rop, sop;
            logic [IW-1:0] cl, sl;
            rop = 2'($urandom_range(0, 3));
            sop = 2'($urandom_range(0, 3));
            cl  = IW'($urandom_range(0, 3));
            sl  = IW'($urandom_range(0, 3));
            cycle(1'($urandom_range(0, 1)), rop, cl,
                  1'($urandom_range(0, 2) == 0), sop, sl,
                  1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
                  IW'($urandom_range(0, 3)), "R13");
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule